// File: doc/BRIEF.md
# DMA Beat Address Generator

This block sequences the byte addresses for one DMA block transfer. Each side (source and destination) has its own start address and its own increment enable. Either side can stay fixed on one address, as for a peripheral data register, or advance after every beat. A start pulse latches the configuration and loads the beat counter. Each beat-done pulse from the bus engine moves both incrementing sides forward on the same edge and counts one beat off. When the last beat completes, a one-cycle block-done flag rises.

One step-select bit decides which side uses the large multi-beat stride. The other incrementing side always advances by one beat. The stride counts beats, and the beat size in bytes scales it. When the block starts, the generator also registers the end address that each side will reach after the last beat. This is the value that control software would compute and write for that side. Bus transfers, arbitration, descriptors and triggers are handled elsewhere.

Top module: `dma_beat_addr_gen`

## Requirements
- R1: After reset, both address outputs, both end outputs and `remaining_o` are 0, and `busy_o` and `block_done_o` are 0.
- R2: On a clock edge with `start_i` high, `src_addr_o` and `dst_addr_o` load `src_start_i` and `dst_start_i`, and `remaining_o` loads `beat_cnt_i`. `busy_o` becomes 1 when the count is nonzero.
- R3: Beat size code `beat_size_i`: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 both mean 4 bytes.
- R4: The multi-beat stride is 2^`step_code_i` beats, from 1 to 128 beats.
- R5: With `step_sel_i`=1, the source side uses the multi-beat stride and the destination side advances one beat. With `step_sel_i`=0, the roles are swapped.
- R6: A side whose increment enable was 0 at start keeps its start address for the whole block.
- R7: A `beat_done_i` pulse while `busy_o`=1 decrements `remaining_o` by one and advances each enabled side by its stride on the same edge. A `beat_done_i` pulse while idle changes no output.
- R8: `block_done_o` is high for exactly one cycle. That cycle follows the edge that took the final beat, or the start edge when the count is 0. `busy_o` is 0 in that cycle, and the address outputs hold afterwards.
- R9: On start, `src_end_o` and `dst_end_o` register start + count × beat bytes × stride beats for an incrementing side, and the start address for a static side. After the last beat, each current address equals its end value.
- R10: All address arithmetic wraps modulo 2^32.
- R11: `start_i` while busy restarts the block. It takes priority over `beat_done_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a block with the present configuration |
| beat_done_i | input | 1 | One beat completed on the bus |
| src_start_i | input | 32 | Source first-beat address |
| dst_start_i | input | 32 | Destination first-beat address |
| beat_size_i | input | 2 | Beat size code |
| beat_cnt_i | input | 16 | Beats in the block |
| src_inc_i | input | 1 | Source increment enable |
| dst_inc_i | input | 1 | Destination increment enable |
| step_sel_i | input | 1 | 1: source takes the multi-beat stride; 0: destination does |
| step_code_i | input | 3 | Stride of 2^code beats |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| src_end_o | output | 32 | Source address after the last beat |
| dst_end_o | output | 32 | Destination address after the last beat |
| remaining_o | output | 16 | Beats still to run |
| busy_o | output | 1 | Block in progress |
| block_done_o | output | 1 | One-cycle block completion flag |

## Verification
Every output is a register, so each result belongs to the cycle right after the edge that samples the stimulus. The start edge loads the addresses, the count and the end values. A beat edge applies the address step and the decrement, and the final beat edge raises `block_done_o`. The bench drives inputs just after the falling edge. It runs a behavioural model on the rising edge and compares all outputs 5 ns later, so each comparison sees the result of exactly one edge. After each block, directed checks compare the final addresses with end values worked out by hand from the formula.

// File: rtl/dma_agen_pkg.sv
package dma_agen_pkg;
  typedef enum logic [1:0] {
    BSZ_1B   = 2'd0,
    BSZ_2B   = 2'd1,
    BSZ_4B   = 2'd2,
    BSZ_4B_X = 2'd3
  } beat_size_e;

  localparam int unsigned BEAT_BYTES_W = 3;

  function automatic logic [BEAT_BYTES_W-1:0] beat_bytes(input logic [1:0] code);
    unique case (beat_size_e'(code))
      BSZ_1B:  beat_bytes = 3'd1;
      BSZ_2B:  beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_agen_stepper.sv
module dma_agen_stepper
  import dma_agen_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned STEP_CODE_W = 3
) (
  input  logic [1:0]             beat_size_i,
  input  logic [STEP_CODE_W-1:0] step_code_i,
  input  logic                   step_sel_i,
  output logic [ADDR_W-1:0]      src_step_o,
  output logic [ADDR_W-1:0]      dst_step_o
);
  logic [ADDR_W-1:0] one_beat, multi_beat;

  always_comb begin
    one_beat   = ADDR_W'(beat_bytes(beat_size_i));
    multi_beat = one_beat << step_code_i;
    src_step_o = step_sel_i ? multi_beat : one_beat;
    dst_step_o = step_sel_i ? one_beat : multi_beat;
  end

  // R4
  always_comb begin
    step_pow2_chk: assert ($countones(multi_beat) == 1);
  end
endmodule

// File: rtl/dma_agen_counter.sv
module dma_agen_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             beat_done_i,
  input  logic [CNT_W-1:0] beat_cnt_i,
  output logic             adv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remaining_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // start wins over a same-cycle beat
  assign adv_o = beat_done_i && busy_o && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remaining_o <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
    end else if (start_i) begin
      remaining_o <= beat_cnt_i;
      busy_o      <= (beat_cnt_i != '0);
      done_o      <= (beat_cnt_i == '0);
    end else if (adv_o) begin
      remaining_o <= remaining_o - ONE;
      busy_o      <= (remaining_o != ONE);
      done_o      <= (remaining_o == ONE);
    end else begin
      done_o      <= 1'b0;
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R7
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> remaining_o == $past(remaining_o) - ONE);
  // R8
  last_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && remaining_o == ONE) |=> (done_o && !busy_o));
  // R7
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !busy_o) |=> ($stable(remaining_o) && !busy_o && !done_o));
endmodule

// File: rtl/dma_agen_side.sv
module dma_agen_side #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  beat_cnt_i,
  input  logic              inc_en_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] end_o
);
  logic              inc_q;
  logic [ADDR_W-1:0] step_q;
  logic [ADDR_W-1:0] span;

  assign span = ADDR_W'(beat_cnt_i) * step_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      end_o  <= '0;
      inc_q  <= 1'b0;
      step_q <= '0;
    end else if (load_i) begin
      addr_o <= start_addr_i;
      end_o  <= inc_en_i ? start_addr_i + span : start_addr_i;
      inc_q  <= inc_en_i;
      step_q <= step_i;
    end else if (adv_i && inc_q) begin
      addr_o <= addr_o + step_q;
    end
  end

  // R6
  static_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !inc_q) |=> $stable(addr_o));
  // R7
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i && inc_q) |=> addr_o == $past(addr_o) + $past(step_q));
  // R9
  end_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(end_o));
  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(start_addr_i));
endmodule

// File: rtl/dma_beat_addr_gen.sv
module dma_beat_addr_gen #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned STEP_CODE_W = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   beat_done_i,
  input  logic [ADDR_W-1:0]      src_start_i,
  input  logic [ADDR_W-1:0]      dst_start_i,
  input  logic [1:0]             beat_size_i,
  input  logic [CNT_W-1:0]       beat_cnt_i,
  input  logic                   src_inc_i,
  input  logic                   dst_inc_i,
  input  logic                   step_sel_i,
  input  logic [STEP_CODE_W-1:0] step_code_i,
  output logic [ADDR_W-1:0]      src_addr_o,
  output logic [ADDR_W-1:0]      dst_addr_o,
  output logic [ADDR_W-1:0]      src_end_o,
  output logic [ADDR_W-1:0]      dst_end_o,
  output logic [CNT_W-1:0]       remaining_o,
  output logic                   busy_o,
  output logic                   block_done_o
);
  localparam int unsigned N_SIDES = 2;  // 0: source, 1: destination

  logic                          adv;
  logic [N_SIDES-1:0][ADDR_W-1:0] side_start, side_step, side_addr, side_end;
  logic [N_SIDES-1:0]             side_inc;

  dma_agen_stepper #(.ADDR_W(ADDR_W), .STEP_CODE_W(STEP_CODE_W)) u_stepper (
    .beat_size_i (beat_size_i),
    .step_code_i (step_code_i),
    .step_sel_i  (step_sel_i),
    .src_step_o  (side_step[0]),
    .dst_step_o  (side_step[1])
  );

  dma_agen_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .beat_done_i (beat_done_i),
    .beat_cnt_i  (beat_cnt_i),
    .adv_o       (adv),
    .busy_o      (busy_o),
    .done_o      (block_done_o),
    .remaining_o (remaining_o)
  );

  assign side_start = {dst_start_i, src_start_i};
  assign side_inc   = {dst_inc_i, src_inc_i};

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    dma_agen_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_side (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .load_i       (start_i),
      .adv_i        (adv),
      .start_addr_i (side_start[g]),
      .beat_cnt_i   (beat_cnt_i),
      .inc_en_i     (side_inc[g]),
      .step_i       (side_step[g]),
      .addr_o       (side_addr[g]),
      .end_o        (side_end[g])
    );
  end

  assign src_addr_o = side_addr[0];
  assign dst_addr_o = side_addr[1];
  assign src_end_o  = side_end[0];
  assign dst_end_o  = side_end[1];

  // R9
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_o |-> (src_addr_o == src_end_o && dst_addr_o == dst_end_o));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (block_done_o && !start_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o)));
endmodule

// File: tb/sim_dma_beat_addr_gen.sv
module sim_dma_beat_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bd = 1'b0;
  logic [31:0] srcs = '0, dsts = '0;
  logic [1:0]  bsz = '0;
  logic [15:0] cnt = '0;
  logic        sinc = 1'b0, dinc = 1'b0, ssel = 1'b0;
  logic [2:0]  code = '0;
  logic [31:0] src_a, dst_a, src_e, dst_e;
  logic [15:0] rem;
  logic        busy, done;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_beat_addr_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .beat_done_i(bd),
    .src_start_i(srcs), .dst_start_i(dsts), .beat_size_i(bsz), .beat_cnt_i(cnt),
    .src_inc_i(sinc), .dst_inc_i(dinc), .step_sel_i(ssel), .step_code_i(code),
    .src_addr_o(src_a), .dst_addr_o(dst_a), .src_end_o(src_e), .dst_end_o(dst_e),
    .remaining_o(rem), .busy_o(busy), .block_done_o(done)
  );

  // behavioural reference model
  longint m_src, m_dst, m_send, m_dend, m_sstep, m_dstep;
  int     m_rem;
  bit     m_busy, m_done, m_sinc, m_dinc;
  localparam longint MASK = 64'hFFFF_FFFF;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_send = 0; m_dend = 0; m_rem = 0;
      m_busy = 0; m_done = 0; m_sinc = 0; m_dinc = 0; m_sstep = 0; m_dstep = 0;
    end else if (start) begin
      longint bb, mb;
      bb = (bsz == 0) ? 1 : (bsz == 1) ? 2 : 4;
      mb = bb * (64'd1 << code);
      m_sstep = ssel ? mb : bb;
      m_dstep = ssel ? bb : mb;
      m_sinc = sinc; m_dinc = dinc;
      m_src = srcs; m_dst = dsts;
      m_send = sinc ? (srcs + longint'(cnt) * m_sstep) & MASK : srcs;
      m_dend = dinc ? (dsts + longint'(cnt) * m_dstep) & MASK : dsts;
      m_rem = cnt; m_busy = (cnt != 0); m_done = (cnt == 0);
    end else if (bd && m_busy) begin
      m_rem = m_rem - 1;
      if (m_sinc) m_src = (m_src + m_sstep) & MASK;
      if (m_dinc) m_dst = (m_dst + m_dstep) & MASK;
      m_busy = (m_rem != 0); m_done = (m_rem == 0);
    end else m_done = 0;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, 5 ns after the rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      chk("R2/R5/R7/R10 src_addr", longint'(src_a), m_src);
      chk("R2/R5/R7/R10 dst_addr", longint'(dst_a), m_dst);
      chk("R9 src_end", longint'(src_e), m_send);
      chk("R9 dst_end", longint'(dst_e), m_dend);
      chk("R7 remaining", longint'(rem), longint'(m_rem));
      chk("R2 busy", longint'(busy), longint'(m_busy));
      chk("R8 block_done", longint'(done), longint'(m_done));
    end
  end

  task automatic finish_run;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic cfg(input logic [31:0] s, input logic [31:0] d, input logic [1:0] b,
                     input logic [15:0] n, input bit si, input bit di, input bit sel,
                     input logic [2:0] c);
    srcs = s; dsts = d; bsz = b; cnt = n; sinc = si; dinc = di; ssel = sel; code = c;
  endtask

  // start, then n beats with gap idle cycles between them (beats during gaps ignored)
  task automatic run_block(input int gap);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 400 && busy; i++) begin
      bd = 1;
      @(negedge clk); bd = 0;
      for (int j = 0; j < gap; j++) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #45;
    // R1 reset state
    chk("R1 src_addr", longint'(src_a), 0);
    chk("R1 dst_end", longint'(dst_e), 0);
    chk("R1 remaining", longint'(rem), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 done", longint'(done), 0);
    rst_n = 1;

    // R5 step_sel=1: source 4B x 2 beats = 8, 5 beats -> +40; dest static (R6)
    cfg(32'h1000, 32'h4000_0000, 2'd2, 16'd5, 1, 0, 1, 3'd1);
    run_block(0);
    chk("R5 src final", longint'(src_a), 64'h1028);
    chk("R6 dst static", longint'(dst_a), 64'h4000_0000);

    // R5 step_sel=0: dest 2B x 2 beats = 4, 3 beats -> +12; source static
    cfg(32'h4000_0010, 32'h2000, 2'd1, 16'd3, 0, 1, 0, 3'd1);
    run_block(2);
    chk("R5 dst final", longint'(dst_a), 64'h200C);
    chk("R6 src static", longint'(src_a), 64'h4000_0010);

    // R3 R4 both incrementing: 1B; dest 8 beats; 4 beats
    cfg(32'h300, 32'h500, 2'd0, 16'd4, 1, 1, 0, 3'd3);
    run_block(1);
    chk("R3 src final", longint'(src_a), 64'h304);
    chk("R4 dst final", longint'(dst_a), 64'h520);

    // R3 code 3 means 4 bytes
    cfg(32'h0, 32'h0, 2'd3, 16'd2, 1, 0, 0, 3'd0);
    run_block(0);
    chk("R3 code3 src", longint'(src_a), 64'h8);

    // R8 count zero: done the cycle after start
    cfg(32'hAA0, 32'hBB0, 2'd2, 16'd0, 1, 1, 1, 3'd2);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R8 zero count done", longint'(done), 1);
    chk("R8 zero count busy", longint'(busy), 0);
    chk("R8 zero count addr", longint'(src_a), 64'hAA0);

    // R10 wrap: 4B x 128 beats = 512, 2 beats
    cfg(32'hFFFF_FFF0, 32'hFFFF_FFFC, 2'd2, 16'd2, 1, 1, 1, 3'd7);
    run_block(0);
    chk("R10 src wrap", longint'(src_a), 64'h3F0);
    chk("R10 dst wrap", longint'(dst_a), 64'h4);

    // R7 beats while idle ignored
    bd = 1; @(negedge clk); @(negedge clk); bd = 0;
    chk("R7 idle src", longint'(src_a), 64'h3F0);
    chk("R7 idle rem", longint'(rem), 0);

    // R11 restart mid-block with concurrent beat
    cfg(32'h100, 32'h200, 2'd2, 16'd6, 1, 1, 1, 3'd0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; bd = 1;
    @(negedge clk);
    cfg(32'h800, 32'h900, 2'd0, 16'd3, 1, 0, 1, 3'd2);
    start = 1;  // bd still high
    @(negedge clk); start = 0; bd = 0;
    chk("R11 restart src", longint'(src_a), 64'h800);
    chk("R11 restart rem", longint'(rem), 3);
    for (int i = 0; i < 3; i++) begin bd = 1; @(negedge clk); bd = 0; end
    chk("R11 restart final", longint'(src_a), 64'h80C);
    @(negedge clk);
    chk("R8 hold after done", longint'(src_a), 64'h80C);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule